// File: doc/BRIEF.md
# Prescaled Timer with Channel Flags

This block holds a free-running 16-bit timer counter whose advance rate comes from the module clock through a power-of-two prescaler. The divide factor is set by a 3-bit select code. Beside the counter sits an 8-bit flag register, one flag for each capture/compare channel. Event pulses from outside the block set the flags, and the flags drive one combined interrupt line through a per-channel enable mask.

Software uses a byte-wide register bus with a single-cycle access strobe and a combinational read path. Through it, software sets the prescale code, the fast-clear and two-capture options and the interrupt enables, reads the counter as two bytes without tearing, and clears flags. A flag clears in one of two ways. The first is write-one-to-clear on the flag register. The second, when fast-clear is on, is any access to one of the channel's two bytes in a 16-byte channel data window.

A new prescale code is held pending. It takes over only at the edge where the whole prescaler chain reads zero, so the counter never sees a short or stretched period.

Top module: `prescaled_timer`

## Requirements
- R1: After reset these all read 0: the control register (address 0x00), the enable register (0x01), the flag register (0x02) and the `irq` output. The counter starts from 0.
- R2: When select code s (control bits 2:0) is active, the counter rises by one every 2^s clock cycles. It wraps from 0xFFFF to 0x0000.
- R3: A written select code becomes active only at the clock edge where the 7-stage prescaler reads all zeros. Until then the old rate continues.
- R4: A read of the counter high byte (address 0x04) returns bits 15:8 and also captures bits 7:0. A later read of address 0x05 returns those captured bits.
- R5: A pulse on `chan_evt[n]` sets flag bit n of the flag register (address 0x02).
- R6: Writing the flag register clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R7: When control bit 4 (fast-clear) is 1, a read or write of address 0x10+2n or 0x11+2n clears flag n. When bit 4 is 0, such accesses leave the flags untouched.
- R8: If an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: When control bit 5 (two-capture mode) is 1, a channel's flag is set only on every second event of that channel.
- R10: `irq` is 1 exactly when some flag bit n is 1 while enable bit n (address 0x01) is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the strobe is held |
| chan_evt | input | 8 | Per-channel event pulses |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
The deferred prescale switch is the hardest case to reach from the ports. The new code has to be written at an arbitrary prescaler phase, and the counter has to be read both before and after the all-zero boundary. The bench keeps an arithmetic model of the prescaler phase and the counter, updated on every edge from the bus writes it issues. It writes codes at many phases, including a slow-to-fast switch in the middle of a period, and compares the assembled two-byte counter reads with the model. It also runs the counter through its wrap and steps through every select code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_CH    = 8;
    localparam int CNT_W   = 16;
    localparam int SEL_W   = 3;
    localparam int PH_W    = (1 << SEL_W) - 1;
    localparam int CH_IDX_W = $clog2(N_CH);

    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_EN   = 8'h01;
    localparam logic [7:0] ADR_FLAG = 8'h02;
    localparam logic [7:0] ADR_CNTH = 8'h04;
    localparam logic [7:0] ADR_CNTL = 8'h05;
    localparam logic [3:0] WIN_HI   = 4'h1;

    localparam int CTRL_FAST = 4;
    localparam int CTRL_PAIR = 5;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_pend,
    output logic             tick
);
    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [SEL_W-1:0] pend;
        logic [SEL_W-1:0] act;
    } presc_t;

    presc_t st_q, st_d;
    logic             at_zero;
    logic [SEL_W-1:0] sel_eff;
    logic [PH_W-1:0]  mask;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.ph == '0);
        sel_eff = at_zero ? st_q.pend : st_q.act;
        mask    = {PH_W{1'b1}} >> (PH_W - int'(sel_eff));
        tick    = ((st_q.ph & mask) == mask);
        st_d.ph = st_q.ph + 1'b1;
        if (at_zero) st_d.act = st_q.pend;
        if (sel_wr)  st_d.pend = sel_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_pend = st_q.pend;

    assert_sel_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != '0) |=> (st_q.act == $past(st_q.act)));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt,
    input  logic            pair,
    input  logic [N_CH-1:0] clr,
    output logic [N_CH-1:0] flags
);
    typedef struct packed {
        logic [N_CH-1:0] flag;
        logic [N_CH-1:0] half;
    } flg_t;

    flg_t st_q, st_d;
    logic [N_CH-1:0] set;

    always_comb begin
        st_d      = st_q;
        set       = pair ? (evt & st_q.half) : evt;
        st_d.half = pair ? (st_q.half ^ evt) : '0;
        st_d.flag = (st_q.flag & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;

    assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flag & ~$past(st_q.flag) & ~$past(evt)) == '0));
    assert_single_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair |=> ((st_q.flag & $past(evt)) == $past(evt)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flag & $past(clr & ~evt)) == '0));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  chan_evt,
    output logic        irq
);
    typedef struct packed {
        logic [N_CH-1:0]   en;
        logic              fast;
        logic              pair;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] lo_hold;
    } top_t;

    top_t st_q, st_d;
    logic             wr_acc, rd_acc, in_win, tick;
    logic [SEL_W-1:0] sel_pend;
    logic [N_CH-1:0]  flags, clr, fast_clr;
    logic [CH_IDX_W-1:0] ch;

    tmr_presc u_presc (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(wr_acc && bus_addr == ADR_CTRL),
        .sel_in(bus_wdata[SEL_W-1:0]),
        .sel_pend(sel_pend), .tick(tick)
    );

    tmr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .evt(chan_evt),
        .pair(st_q.pair), .clr(clr), .flags(flags)
    );

    always_comb begin
        st_d     = st_q;
        wr_acc   = bus_sel && bus_wr;
        rd_acc   = bus_sel && !bus_wr;
        in_win   = (bus_addr[7:4] == WIN_HI);
        ch       = bus_addr[CH_IDX_W:1];
        fast_clr = (st_q.fast && bus_sel && in_win) ? (N_CH'(1) << ch) : '0;
        clr      = fast_clr | ((wr_acc && bus_addr == ADR_FLAG) ? bus_wdata : '0);
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
        if (wr_acc && bus_addr == ADR_CTRL) begin
            st_d.fast = bus_wdata[CTRL_FAST];
            st_d.pair = bus_wdata[CTRL_PAIR];
        end
        if (wr_acc && bus_addr == ADR_EN) st_d.en = bus_wdata;
        if (rd_acc && bus_addr == ADR_CNTH) st_d.lo_hold = st_q.cnt[BYTE_W-1:0];
        bus_rdata = '0;
        if (rd_acc) begin
            case (bus_addr)
                ADR_CTRL: bus_rdata = {2'b00, st_q.pair, st_q.fast, 1'b0, sel_pend};
                ADR_EN:   bus_rdata = st_q.en;
                ADR_FLAG: bus_rdata = flags;
                ADR_CNTH: bus_rdata = st_q.cnt[CNT_W-1:BYTE_W];
                ADR_CNTL: bus_rdata = st_q.lo_hold;
                default:  bus_rdata = '0;
            endcase
        end
        irq = |(flags & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
    assert_fast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.fast && bus_sel && in_win) |-> (fast_clr == '0));
endmodule

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_sel = 1'b0, b_wr = 1'b0;
    logic [7:0] b_addr = '0, b_wdata = '0, b_rdata, evt = '0;
    logic       irq;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    prescaled_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .chan_evt(evt), .irq(irq)
    );

    // arithmetic model of prescaler phase and counter
    logic [6:0]  m_ph;
    logic [2:0]  m_pend, m_act, m_eff;
    logic [15:0] m_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= '0; m_pend <= '0; m_act <= '0; m_cnt <= '0;
        end else begin
            m_eff = (m_ph == 0) ? m_pend : m_act;
            if ((int'(m_ph) % (1 << m_eff)) == (1 << m_eff) - 1) m_cnt <= m_cnt + 16'd1;
            if (m_ph == 0) m_act <= m_pend;
            m_ph <= m_ph + 7'd1;
            if (b_sel && b_wr && b_addr == 8'h00) m_pend <= b_wdata[2:0];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input [7:0] a, input [7:0] d);
        @(negedge clk); b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d;
        @(posedge clk); #1 b_sel = 0; b_wr = 0;
    endtask

    task automatic rd(input [7:0] a, output [7:0] d);
        @(negedge clk); b_sel = 1; b_wr = 0; b_addr = a;
        #1 d = b_rdata;
        @(posedge clk); #1 b_sel = 0;
    endtask

    task automatic rd_cnt(output [15:0] v, output [15:0] exp);
        logic [7:0] lo;
        @(negedge clk); b_sel = 1; b_wr = 0; b_addr = 8'h04;
        #1 v[15:8] = b_rdata; exp = m_cnt;
        @(posedge clk); #1 b_sel = 0;
        repeat (3) @(negedge clk);
        rd(8'h05, lo);
        v[7:0] = lo;
    endtask

    task automatic pulse(input [7:0] v);
        @(negedge clk); evt = v;
        @(posedge clk); #1 evt = '0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v, e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(8'h00, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        rd(8'h01, d); chk(d == 8'h00, "R1 enable", d, 0);
        rd(8'h02, d); chk(d == 8'h00, "R1 flags", d, 0);
        @(negedge clk); chk(irq == 1'b0, "R1 irq", irq, 0);
        rd_cnt(v, e); chk(v == e && e < 16'd20, "R1 counter start", v, e);

        // R2 every select code, R4 tear-free read
        for (int s = 0; s < 8; s++) begin
            wr(8'h00, 8'(s));
            waitc(130 + 7 * s);
            rd_cnt(v, e); chk(v == e, $sformatf("R2 rate sel=%0d", s), v, e);
            waitc(200 + 13 * s);
            rd_cnt(v, e); chk(v == e, $sformatf("R4 counter pair sel=%0d", s), v, e);
        end

        // R3 deferred switch at varied phases
        for (int k = 0; k < 6; k++) begin
            wr(8'h00, 8'd7);
            waitc(140);
            waitc(11 * k + 3);
            wr(8'h00, 8'(k % 3));
            rd(8'h00, d); chk(d[2:0] == 3'(k % 3), "R3 pending code readback", d, k % 3);
            rd_cnt(v, e); chk(v == e, "R3 old rate kept", v, e);
            waitc(150);
            rd_cnt(v, e); chk(v == e, "R3 new rate applied", v, e);
        end

        // R2 wrap
        wr(8'h00, 8'd0);
        waitc(130);
        while (m_cnt < 16'hFFF0) @(negedge clk);
        waitc(30);
        rd_cnt(v, e); chk(v == e && e < 16'h0030, "R2 wrap", v, e);

        // R5 each channel sets its own bit
        for (int c = 0; c < 8; c++) begin
            pulse(8'(1 << c));
            rd(8'h02, d); chk(d == 8'((2 << c) - 1), $sformatf("R5 ch%0d", c), d, (2 << c) - 1);
        end

        // R6 write-one-to-clear
        wr(8'h02, 8'h0F);
        rd(8'h02, d); chk(d == 8'hF0, "R6 w1c", d, 8'hF0);
        wr(8'h02, 8'h00);
        rd(8'h02, d); chk(d == 8'hF0, "R6 zero no effect", d, 8'hF0);
        wr(8'h02, 8'hFF);
        rd(8'h02, d); chk(d == 8'h00, "R6 clear all", d, 0);

        // R7 fast clear
        pulse(8'hFF);
        rd(8'h12, d); wr(8'h17, 8'h55);
        rd(8'h02, d); chk(d == 8'hFF, "R7 fast off no effect", d, 8'hFF);
        wr(8'h00, 8'h10);
        for (int c = 0; c < 8; c++) begin
            if (c % 2 == 0) rd(8'(8'h10 + 2 * c + (c / 2) % 2), d);
            else            wr(8'(8'h10 + 2 * c + (c / 2) % 2), 8'h00);
            rd(8'h02, d);
            chk(d == 8'(8'hFF << (c + 1)), $sformatf("R7 fast clear ch%0d", c), d, 8'(8'hFF << (c + 1)));
        end
        wr(8'h00, 8'h00);

        // R8 set wins
        @(negedge clk); evt = 8'h24; b_sel = 1; b_wr = 1; b_addr = 8'h02; b_wdata = 8'h24;
        @(posedge clk); #1 evt = 0; b_sel = 0; b_wr = 0;
        rd(8'h02, d); chk(d == 8'h24, "R8 set beats clear", d, 8'h24);
        wr(8'h02, 8'hFF);

        // R9 two-capture mode
        wr(8'h00, 8'h20);
        pulse(8'h08);
        rd(8'h02, d); chk(d == 8'h00, "R9 first event no flag", d, 0);
        pulse(8'h08);
        rd(8'h02, d); chk(d == 8'h08, "R9 second event flag", d, 8'h08);
        pulse(8'h08);
        rd(8'h02, d); wr(8'h02, 8'hFF);
        pulse(8'h08);
        rd(8'h02, d); chk(d == 8'h08, "R9 fourth event flag", d, 8'h08);
        wr(8'h00, 8'h00); wr(8'h02, 8'hFF);

        // R10 interrupt
        wr(8'h01, 8'h04);
        pulse(8'h08);
        @(negedge clk); chk(irq == 1'b0, "R10 disabled flag", irq, 0);
        pulse(8'h04);
        @(negedge clk); chk(irq == 1'b1, "R10 enabled flag", irq, 1);
        wr(8'h02, 8'h04);
        @(negedge clk); chk(irq == 1'b0, "R10 after clear", irq, 0);
        rd(8'h01, d); chk(d == 8'h04, "R10 enable readback", d, 8'h04);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule